// File: doc/BRIEF.md
# Relocatable Write-Only Colour Overlay Decoder

This block places a 1 KB colour attribute window anywhere in a 64 KB processor address space, on any 1 KB boundary. Software loads an 8-bit control latch. The low six bits choose the 1 KB page that the window occupies. One further bit switches the overlay on or off.

When the overlay is on, a processor write whose address lands inside the window is copied into the colour RAM. The same write still reaches the ordinary memory behind the window. Processor reads are never taken from the colour RAM: they always come from the memory that lies behind the window. If software places the window behind spare ordinary RAM, the colour map written through the window can therefore be read back from that RAM.

The block drives the colour RAM's address and write-enable signals. It passes the processor's read and write strobes on to the underlying memory without changing them. The colour RAM itself lies outside this block.

Top module: `overlay_window_decoder`

## Requirements
- R1: A synchronous active-low reset clears the control latch to 0x00. While the latch is zero the overlay is disabled, so `win_hit` and `cram_we` stay low.
- R2: A latch write stores bits 6..0 of `latch_din`. Bit 7 is reserved and always reads as 0 on `latch_q`. The new value appears on `latch_q` right after the clock edge that samples `latch_wr`, and `latch_q` holds its value when there is no latch write.
- R3: `win_hit` is 1 exactly when latch bit 6 (the enable bit) is 1 and `cpu_addr[15:10]` equals latch bits 5..0. Latch bits 5..0 are the base address in 1 KB pages.
- R4: `cram_addr` always equals `cpu_addr[9:0]`, which is the byte offset inside the window (one byte per character cell).
- R5: `cram_we` is high exactly when `win_hit` and `cpu_wr` are both high. A read in the window never asserts `cram_we`.
- R6: When latch bit 6 is 0, no address produces `win_hit` or `cram_we`.
- R7: `mem_rd` equals `cpu_rd` and `mem_wr` equals `cpu_wr` in every cycle, whether or not the address hits the window. Reads and writes therefore always reach the underlying memory.
- R8: A latch write does not change the decode of the bus cycle in which it occurs. The new base and enable apply from the next cycle onward.
- R9: The first byte of the window (`base*1024`) and its last byte (`base*1024+1023`) both hit. The byte just below the window and the byte just above it both miss. This holds for every base, including base 0 and base 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| latch_wr | input | 1 | Control latch write strobe |
| latch_din | input | 8 | Control latch data: bits 5..0 base page, bit 6 enable, bit 7 ignored |
| latch_q | output | 8 | Current latch value, bit 7 always 0 |
| cpu_addr | input | 16 | Processor address bus |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| win_hit | output | 1 | Address lies in the enabled window |
| cram_addr | output | 10 | Colour RAM byte address |
| cram_we | output | 1 | Colour RAM write enable |
| mem_rd | output | 1 | Read strobe passed on to the underlying memory |
| mem_wr | output | 1 | Write strobe passed on to the underlying memory |

## Verification
The assertions check the following on every cycle:
- The reserved latch bit stays zero.
- The latch loads on a latch write and holds its value otherwise.
- No hit or colour write occurs while the overlay is disabled.
- No colour write occurs on a read.
- A hit always matches the base.
- The strobes pass through unchanged.

The bench scenarios are the only way to show the following:
- That the exact window edges hit or miss at the lowest page, the highest page and a middle page.
- That a latch write leaves the decode of its own cycle alone and moves the window one cycle later.
- That a reset in the middle of a run removes an active overlay.

// File: rtl/ovl_pkg.sv
// Package ovl_pkg
// Purpose: shared constants for the overlay decoder's latch layout.
// Assumes: the latch is base page bits, then one enable bit, then one reserved bit.
package ovl_pkg;
    localparam int ENA_OFS = 0;   // enable sits just above the base field
    localparam int RSV_OFS = 1;   // reserved bit sits above the enable

    // Build the stored latch image: the reserved bit is forced to zero.
    function automatic logic [7:0] clean_latch(input logic [7:0] raw);
        clean_latch = {1'b0, raw[6:0]};
    endfunction
endpackage

// File: rtl/ovl_ctrl_latch.sv
// Module ovl_ctrl_latch
// Purpose: holds the overlay control word (base page and enable).
// Assumes: a synchronous active-low reset; the reserved top bit is stored as zero.
module ovl_ctrl_latch #(
    parameter int BASE_W = 6,
    localparam int LAT_W = BASE_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [LAT_W-1:0] din,
    output logic [LAT_W-1:0] q
);
    // Load the base and enable on a write; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr)
            q <= {1'b0, din[BASE_W:0]};
    end
endmodule

// File: rtl/ovl_window_match.sv
// Module ovl_window_match
// Purpose: compares the upper address bits with the latched base page.
// Assumes: the window is 2**WIN_W bytes and aligned to its own size.
module ovl_window_match #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 10,
    localparam int BASE_W = ADDR_W - WIN_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    input  logic              enable,
    output logic              hit
);
    logic [BASE_W-1:0] bit_eq;

    // One equality cell per base bit.
    for (genvar g = 0; g < BASE_W; g++) begin : g_cmp
        assign bit_eq[g] = ~(addr[WIN_W+g] ^ base[g]);
    end

    // A hit needs every bit to match and the overlay to be on.
    always_comb begin
        hit = enable & (&bit_eq);
    end
endmodule

// File: rtl/ovl_strobe_gate.sv
// Module ovl_strobe_gate
// Purpose: drives the colour RAM strobes and passes the memory strobes through.
// Assumes: the colour RAM is never read by the processor; write strobes are active high.
module ovl_strobe_gate #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 10
) (
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [WIN_W-1:0]  cram_addr,
    output logic              cram_we,
    output logic              mem_rd,
    output logic              mem_wr
);
    // Colour RAM offset, write gating, and an unchanged memory path.
    always_comb begin
        cram_addr = addr[WIN_W-1:0];
        cram_we   = hit & cpu_wr;
        mem_rd    = cpu_rd;
        mem_wr    = cpu_wr;
    end
endmodule

// File: rtl/overlay_window_decoder.sv
// Module overlay_window_decoder
// Purpose: top level of the relocatable write-only colour overlay decoder.
// Assumes: the latch is registered and the decode is combinational, so a latch
//          write acts from the cycle after the edge that samples it.
module overlay_window_decoder #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 10,
    localparam int BASE_W = ADDR_W - WIN_W,
    localparam int LAT_W  = BASE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_wr,
    input  logic [LAT_W-1:0]  latch_din,
    output logic [LAT_W-1:0]  latch_q,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic              win_hit,
    output logic [WIN_W-1:0]  cram_addr,
    output logic              cram_we,
    output logic              mem_rd,
    output logic              mem_wr
);
    import ovl_pkg::*;

    localparam int ENA_BIT = BASE_W + ENA_OFS;

    logic [LAT_W-1:0] ctl;

    ovl_ctrl_latch #(.BASE_W(BASE_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (latch_wr),
        .din   (latch_din),
        .q     (ctl)
    );

    ovl_window_match #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_match (
        .addr   (cpu_addr),
        .base   (ctl[BASE_W-1:0]),
        .enable (ctl[ENA_BIT]),
        .hit    (win_hit)
    );

    ovl_strobe_gate #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_gate (
        .hit       (win_hit),
        .addr      (cpu_addr),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cram_addr (cram_addr),
        .cram_we   (cram_we),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    // Expose the stored control word.
    always_comb latch_q = ctl;
endmodule

// File: rtl/overlay_window_decoder_chk.sv
// Module overlay_window_decoder_chk
// Purpose: property checks for the overlay decoder, attached with bind.
// Assumes: the default 16-bit address and 10-bit window.
module overlay_window_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        latch_wr,
    input logic [7:0]  latch_din,
    input logic [7:0]  latch_q,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic        win_hit,
    input logic        cram_we,
    input logic        mem_rd,
    input logic        mem_wr
);
    // R1: the first cycle after reset shows a cleared latch.
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> latch_q == 8'h00);

    // R2: the reserved bit stays zero.
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        latch_q[7] == 1'b0);

    // R2: a latch write loads the low seven bits.
    a_r2_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        latch_wr |=> latch_q == {1'b0, $past(latch_din[6:0])});

    // R2: with no latch write, the latch holds its value.
    a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_wr |=> $stable(latch_q));

    // R3: a hit always matches the base page and needs the enable bit.
    a_r3_hit_matches: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (cpu_addr[15:10] == latch_q[5:0]) && latch_q[6]);

    // R5: a read never writes the colour RAM.
    a_r5_no_we_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |-> !cram_we);

    // R6: while disabled, there is no hit and no colour write.
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_q[6] |-> !win_hit && !cram_we);

    // R7: the memory strobes follow the processor strobes.
    a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd == cpu_rd && mem_wr == cpu_wr);
endmodule

bind overlay_window_decoder overlay_window_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_wr  (latch_wr),
    .latch_din (latch_din),
    .latch_q   (latch_q),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .win_hit   (win_hit),
    .cram_we   (cram_we),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
);

// File: tb/test_overlay_window_decoder.sv
`timescale 1ns/1ps
module test_overlay_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        latch_wr = 1'b0;
    logic [7:0]  latch_din = 8'h00;
    logic [7:0]  latch_q;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        win_hit;
    logic [9:0]  cram_addr;
    logic        cram_we;
    logic        mem_rd;
    logic        mem_wr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit model_valid = 1'b0;
    int ref_latch = 0;   // behavioural model of the control word
    string tag = "R1";

    always #2 clk = ~clk;   // 250 MHz

    overlay_window_decoder i_overlay_window_decoder (
        .clk(clk), .rst_n(rst_n), .latch_wr(latch_wr), .latch_din(latch_din),
        .latch_q(latch_q), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .win_hit(win_hit), .cram_addr(cram_addr), .cram_we(cram_we),
        .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    // Reference model: update the control word from the requirement text (R1, R2).
    always @(posedge clk) begin
        if (!rst_n) ref_latch <= 0;
        else if (latch_wr) ref_latch <= int'(latch_din) % 128;
        model_valid <= 1'b1;
    end

    task automatic cmp(string req, int act, int exp_v, string what);
        n_run++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp_v, $time);
        end
    endtask

    // Compare every output against the model on every falling edge.
    always @(negedge clk) begin
        if (model_valid && !done) begin
            int base_pg;
            bit en;
            bit exp_hit;
            base_pg = ref_latch % 64;
            en      = (ref_latch / 64) % 2 == 1;
            exp_hit = en && (int'(cpu_addr) / 1024 == base_pg);
            cmp(tag, int'(latch_q), ref_latch, "latch_q");
            cmp(tag, int'(win_hit), int'(exp_hit), "win_hit");
            cmp(tag, int'(cram_we), int'(exp_hit && cpu_wr), "cram_we");
            cmp(tag, int'(cram_addr), int'(cpu_addr) % 1024, "cram_addr");
            cmp(tag, int'(mem_rd), int'(cpu_rd), "mem_rd");
            cmp(tag, int'(mem_wr), int'(cpu_wr), "mem_wr");
        end
    end

    task automatic cyc(string t, bit lw, logic [7:0] ld, logic [15:0] a, bit rd, bit wr);
        @(posedge clk);
        #1;
        tag = t; latch_wr = lw; latch_din = ld; cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
    endtask

    // Apply a bus cycle and confirm the expected hit directly at the ports.
    task automatic probe(string t, logic [15:0] a, bit wr, bit exp_hit);
        cyc(t, 1'b0, 8'h00, a, !wr, wr);
        @(negedge clk);
        cmp(t, int'(win_hit), int'(exp_hit), "probe win_hit");
    endtask

    initial begin
        // R1: reset state
        cyc("R1", 0, 8'h00, 16'h0000, 0, 0);
        cyc("R1", 0, 8'h00, 16'h0000, 0, 1);
        @(negedge clk);
        cmp("R1", int'(latch_q), 0, "reset latch");
        cmp("R1", int'(cram_we), 0, "reset cram_we");
        rst_n = 1'b1;
        probe("R6", 16'h0000, 1, 0);   // disabled: base 0 write does not hit
        // R2: bit 7 is dropped; 0xFF sets base 63 and enable
        cyc("R2", 1, 8'hFF, 16'h1234, 0, 0);
        @(negedge clk);
        @(negedge clk);
        cmp("R2", int'(latch_q), 8'h7F, "latch load");
        // R9: edges of page 63
        probe("R9", 16'hFC00, 1, 1);
        probe("R9", 16'hFFFF, 1, 1);
        probe("R9", 16'hFBFF, 1, 0);
        // R5 and R7: a read inside the window reaches memory, not the colour RAM
        cyc("R5", 0, 8'h00, 16'hFC10, 1, 0);
        @(negedge clk);
        cmp("R5", int'(cram_we), 0, "read no we");
        cmp("R7", int'(mem_rd), 1, "read passthru");
        // R3 and R4: base 0x12 with enable means window 0x4800..0x4BFF
        cyc("R3", 1, 8'h52, 16'h0000, 0, 0);
        probe("R9", 16'h4800, 1, 1);
        probe("R9", 16'h4BFF, 1, 1);
        probe("R9", 16'h47FF, 1, 0);
        probe("R9", 16'h4C00, 1, 0);
        cyc("R4", 0, 8'h00, 16'h4A5C, 0, 1);
        @(negedge clk);
        cmp("R4", int'(cram_addr), 10'h25C, "offset");
        cmp("R7", int'(mem_wr), 1, "write passthru on hit");
        // R8: a latch write in the same cycle as a write to page 0 uses the old base
        cyc("R8", 1, 8'h40, 16'h0005, 0, 1);
        @(negedge clk);
        cmp("R8", int'(cram_we), 0, "old base same cycle");
        cyc("R8", 0, 8'h00, 16'h0005, 0, 1);
        @(negedge clk);
        cmp("R8", int'(cram_we), 1, "new base next cycle");
        // R9: edges of page 0
        probe("R9", 16'h03FF, 1, 1);
        probe("R9", 16'h0400, 1, 0);
        // R6: base 0x12 without enable gives no hit
        cyc("R6", 1, 8'h12, 16'h0000, 0, 0);
        probe("R6", 16'h4800, 1, 0);
        // R1: a reset in mid-run clears an active overlay
        cyc("R1", 1, 8'h41, 16'h0000, 0, 0);
        probe("R3", 16'h0400, 1, 1);
        rst_n = 1'b0;
        cyc("R1", 0, 8'h00, 16'h0400, 0, 1);
        @(negedge clk);
        @(negedge clk);
        cmp("R1", int'(latch_q), 0, "mid-run reset");
        cmp("R1", int'(cram_we), 0, "mid-run reset we");
        rst_n = 1'b1;
        // Sweep every base page and check both window edges (R9)
        for (int p = 0; p < 64; p++) begin
            cyc("R9", 1, 8'(64 + p), 16'h0000, 0, 0);
            cyc("R9", 0, 8'h00, 16'(p * 1024), 0, 1);
            cyc("R9", 0, 8'h00, 16'(p * 1024 + 1023), 0, 1);
        end
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule